// File: doc/BRIEF.md
# Busy-Acknowledge Request Retry Controller

This block handles the retransmission of one outgoing request packet on a serial-bus link layer. A start pulse makes it ask the packet transmitter to send the request. The transmitter answers with a done pulse, and the acknowledge code returned by the far node arrives in the same cycle. Any code other than busy ends the sequence at once. The block then reports completion and keeps the received code in its status.

A busy code starts a retry, as long as the programmed retry limit has not been reached. The controller waits a programmed number of time-base ticks. It then asks for the same packet again, with the two-bit retry field set to 01. Only one retry phase exists, so every resend carries 01 and there is no alternation. When the limit is used up and the node still answers busy, the block sets a busy-timeout error code and raises a sticky interrupt. The interrupt stays set until software clears it.

Top module: `busy_retry_ctrl`

## Requirements
- R1: After reset, tx_go_o, tx_rcode_o, busy_o, done_o, err_code_o, irq_o and ack_last_o are all zero.
- R2: A start_i pulse while idle raises busy_o and tx_go_o in the next cycle. tx_go_o stays high until a tx_done_i pulse. A start_i while a sequence is active has no effect on the sequence.
- R3: The first transmission of a sequence carries tx_rcode_o = 2'b00.
- R4: Any acknowledge code other than busy (busy is 4'h4) ends the sequence. In the cycle after tx_done_i, done_o pulses for one cycle, busy_o falls, err_code_o is 2'b00 and ack_last_o holds the received code.
- R5: A busy acknowledge with retries remaining drops tx_go_o. After the wait, tx_go_o rises again with tx_rcode_o = 2'b01, for every retransmission.
- R6: The wait before a retransmission is exactly cfg_gap_i pulses of tick_i, counted after the busy acknowledge. With cfg_gap_i = 0 the resend request follows after one cycle with tx_go_o low.
- R7: At most cfg_limit_i retransmissions happen. A busy acknowledge on attempt cfg_limit_i+1 ends the sequence with done_o, err_code_o = 2'b01 (busy timeout) and irq_o set.
- R8: With cfg_limit_i = 0, the first busy acknowledge goes straight to the busy-timeout error with no retransmission.
- R9: irq_o stays set until an irq_clr_i pulse. A new timeout in the same cycle as a clear leaves it set.
- R10: A new start clears err_code_o to 2'b00 in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a request sequence |
| tick_i | input | 1 | Time-base enable for the retry gap |
| cfg_limit_i | input | LIMIT_W | Maximum number of retransmissions |
| cfg_gap_i | input | GAP_W | Retry gap in ticks |
| tx_go_o | output | 1 | Request to the transmitter to send the packet |
| tx_rcode_o | output | 2 | Retry code to place in the packet |
| tx_done_i | input | 1 | Transmitter finished; ack code valid |
| ack_code_i | input | ACK_W | Acknowledge code returned |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| busy_o | output | 1 | Sequence active |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 2 | 00 none, 01 busy timeout |
| ack_last_o | output | ACK_W | Last acknowledge code received |
| irq_o | output | 1 | Sticky error interrupt |

## Verification
The bench tries four kinds of sequence and follows each with a per-cycle reference model. The first is an immediate non-busy acknowledge, which separates completion from the retry path. The second is several busy answers ending in a completion, which shows the retry code switching to 01 and the gap measured in ticks rather than clocks. The third and fourth are sequences that stay busy with limit 2 and with limit 0, which place the timeout boundary exactly. Further runs check a zero gap, a start during an active sequence, and an interrupt clear that lands in the same cycle as a new timeout, which tells set priority from clear priority.

// File: rtl/busy_retry_ctrl.sv
module busy_retry_ctrl #(
  parameter int ACK_W   = 4,
  parameter int LIMIT_W = 4,
  parameter int GAP_W   = 8,
  parameter logic [ACK_W-1:0] ACK_BUSY = 4'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic [LIMIT_W-1:0] cfg_limit_i,
  input  logic [GAP_W-1:0]   cfg_gap_i,
  output logic               tx_go_o,
  output logic [1:0]         tx_rcode_o,
  input  logic               tx_done_i,
  input  logic [ACK_W-1:0]   ack_code_i,
  input  logic               irq_clr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         err_code_o,
  output logic [ACK_W-1:0]   ack_last_o,
  output logic               irq_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} st_t;
  localparam logic [1:0] ERR_NONE = 2'b00, ERR_BUSY_TO = 2'b01;

  st_t st;
  logic [LIMIT_W-1:0] tries;
  logic [GAP_W-1:0]   gap_cnt;

  wire ack_busy  = tx_done_i && (ack_code_i == ACK_BUSY);
  wire exhausted = tries >= cfg_limit_i;
  wire timeout   = (st == ST_SEND) && ack_busy && exhausted;

  assign tx_go_o = (st == ST_SEND);
  assign busy_o  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tries      <= '0;
      gap_cnt    <= '0;
      tx_rcode_o <= 2'b00;
      done_o     <= 1'b0;
      err_code_o <= ERR_NONE;
      ack_last_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st         <= ST_SEND;
          tries      <= '0;
          tx_rcode_o <= 2'b00;
          err_code_o <= ERR_NONE;
        end
        ST_SEND: if (tx_done_i) begin
          ack_last_o <= ack_code_i;
          if (!ack_busy || exhausted) begin
            st     <= ST_IDLE;
            done_o <= 1'b1;
            if (ack_busy) err_code_o <= ERR_BUSY_TO;
          end else begin
            st      <= ST_GAP;
            tries   <= tries + 1'b1;
            gap_cnt <= '0;
          end
        end
        ST_GAP: begin
          if (gap_cnt >= cfg_gap_i) begin
            st         <= ST_SEND;
            tx_rcode_o <= 2'b01;
          end else if (tick_i) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_o <= 1'b0;
    else if (timeout)   irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end

  assert_first_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_i) |=> (tx_go_o && tx_rcode_o == 2'b00));

  assert_resend_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && gap_cnt >= cfg_gap_i) |=> (tx_go_o && tx_rcode_o == 2'b01));

  assert_nonbusy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go_o && tx_done_i && ack_code_i != ACK_BUSY) |=>
      (!busy_o && done_o && err_code_o == ERR_NONE && ack_last_o == $past(ack_code_i)));

  assert_gap_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && gap_cnt < cfg_gap_i) |=> (!tx_go_o && busy_o));

  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go_o && ack_busy && tries >= cfg_limit_i) |=>
      (done_o && err_code_o == ERR_BUSY_TO && irq_o && !busy_o));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && start_i && gap_cnt < cfg_gap_i) |=> (st == ST_GAP && $stable(tries)));
endmodule

// File: tb/test_busy_retry_ctrl.sv
module test_busy_retry_ctrl;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, tick_i = 0, tx_done_i = 0, irq_clr_i = 0;
  logic [3:0] cfg_limit_i = 0, ack_code_i = 0;
  logic [7:0] cfg_gap_i = 0;
  logic tx_go_o, busy_o, done_o, irq_o;
  logic [1:0] tx_rcode_o, err_code_o;
  logic [3:0] ack_last_o;

  busy_retry_ctrl i_busy_retry_ctrl (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int m_phase = 0, m_tries = 0, m_cnt = 0, m_rcode = 0, m_err = 0, m_ack = 0;
  bit m_done = 0, m_irq = 0;
  int ackq[$];
  int sends = 0;

  always @(posedge clk) if (rst_n) begin
    if (irq_clr_i) m_irq = 0;
    m_done = 0;
    if (m_phase == 0) begin
      if (start_i) begin m_phase = 1; m_tries = 0; m_rcode = 0; m_err = 0; end
    end else if (m_phase == 1) begin
      if (tx_done_i) begin
        m_ack = ack_code_i;
        if (ack_code_i != 4) begin m_done = 1; m_phase = 0; end
        else if (m_tries >= cfg_limit_i) begin m_done = 1; m_err = 1; m_irq = 1; m_phase = 0; end
        else begin m_tries++; m_cnt = 0; m_phase = 2; end
      end
    end else begin
      if (m_cnt >= cfg_gap_i) begin m_phase = 1; m_rcode = 1; end
      else if (tick_i) m_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 tx_go", tx_go_o, m_phase == 1);
    chk("R2 busy", busy_o, m_phase != 0);
    chk("R5 rcode", tx_rcode_o, m_rcode);
    chk("R4 done", done_o, m_done);
    chk("R7 err", err_code_o, m_err);
    chk("R4 ack_last", ack_last_o, m_ack);
    chk("R9 irq", irq_o, m_irq);
  end

  task automatic run(input int lat, input int tdiv, input int extra_start, input bit clr_at_end);
    int w = 0;
    int cyc = 0;
    bit fin = 0;
    sends = 0;
    @(negedge clk); #1 start_i = 1;
    @(negedge clk); #1 start_i = 0;
    chk("R3 first code", tx_rcode_o, 0);
    while (!fin && cyc < 3000) begin
      @(negedge clk); #1;
      cyc++;
      if (done_o) fin = 1;
      tx_done_i = 0; irq_clr_i = 0;
      tick_i = (cyc % tdiv) == 0;
      start_i = (cyc == extra_start);
      if (!fin && tx_go_o) begin
        if (w == lat) begin
          tx_done_i = 1; ack_code_i = 4'(ackq.pop_front()); w = 0; sends++;
          if (clr_at_end && ackq.size() == 0) irq_clr_i = 1;
        end else w++;
      end
    end
    @(negedge clk); #1 tx_done_i = 0; start_i = 0; tick_i = 0; irq_clr_i = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx_go", tx_go_o, 0); chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 err", err_code_o, 0); chk("R1 irq", irq_o, 0); chk("R1 ack", ack_last_o, 0);
    chk("R1 rcode", tx_rcode_o, 0);
    #1 rst_n = 1;
    // R4: immediate complete
    cfg_limit_i = 3; cfg_gap_i = 3;
    ackq = '{1}; run(2, 1, -1, 0);
    chk("R4 single send", sends, 1);
    // R5 R6: busy twice then pending, ticks every 3 cycles, stray start (R2)
    ackq = '{4, 4, 2}; run(1, 3, 6, 0);
    chk("R5 resend count", sends, 3);
    chk("R4 code kept", ack_last_o, 2);
    // R7: timeout at limit 2
    cfg_limit_i = 2;
    ackq = '{4, 4, 4}; run(0, 2, 4, 0);
    chk("R7 attempts", sends, 3);
    chk("R7 irq", irq_o, 1);
    // R10: new start clears error; R6 gap zero
    cfg_gap_i = 0;
    ackq = '{4, 1}; run(0, 1, -1, 0);
    chk("R6 gap0 sends", sends, 2);
    chk("R10 err cleared", err_code_o, 0);
    chk("R9 irq still set", irq_o, 1);
    // R9: clear pulse
    @(negedge clk); #1 irq_clr_i = 1;
    @(negedge clk); #1 irq_clr_i = 0;
    chk("R9 cleared", irq_o, 0);
    // R8 limit zero, clear coinciding with timeout (R9 set wins)
    cfg_limit_i = 0; cfg_gap_i = 5;
    ackq = '{4}; run(1, 1, -1, 1);
    chk("R8 no resend", sends, 1);
    chk("R8 err", err_code_o, 1);
    chk("R9 set wins", irq_o, 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule